// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block is the digital sequencer for one synchronous buck half-bridge. It takes a PWM command that has already been qualified into high, low or idle. From that command it produces the high-side and low-side gate enables. Before either gate is switched on, the sequencer waits for a comparator to confirm that the opposite switch has really turned off. There is no fixed programmed dead time.

When the command rises, the low-side gate is dropped first. The high-side gate is enabled only after the low-side gate comparator has reported "below threshold" for a deadband of clock cycles. When the command falls, the high-side gate is dropped first. The low-side gate is enabled after the switch-node comparator has reported "below threshold" for the same deadband. The switch node may never fall, for example at light load. For that case, the high-side gate-source comparator starts a fallback timer, and when the timer expires the low-side gate is forced on.

A skip-mode input gives diode emulation by keeping the low-side gate off. The enable input, a supply-lockout input and the idle command each force both gates off.

Top module: `halfbridge_gate_seq`

## Requirements
- R1: While rst_ni is low both gate outputs are 0. After reset both stay 0 for as long as the command is idle.
- R2: hs_gate_o and ls_gate_o are never 1 in the same cycle.
- R3: A command change to high (pwm_cmd_i = 2'b01) drops ls_gate_o at the next clock edge. hs_gate_o then rises only after lsg_low_i has been sampled high on DEAD_CYC consecutive edges. With a comparator that trips one cycle after the gate falls, this gives exactly DEAD_CYC cycles with both gates off. If the command returns low during that wait, hs_gate_o never rises.
- R4: A command change to low (pwm_cmd_i = 2'b00) drops hs_gate_o at the next edge. ls_gate_o then rises after sw_low_i has been sampled high on DEAD_CYC consecutive edges. If sw_low_i arrives k edges late, the both-off gap grows by k cycles.
- R5: Once hsvgs_low_i is seen during the low-side wait, a timer of TMO_CYC edges starts and keeps running. When it expires, ls_gate_o is forced on even though sw_low_i never tripped. TMO_CYC must exceed DEAD_CYC.
- R6: While skip_ni is 0, ls_gate_o is 0 in that same cycle. In this mode hs_gate_o rises at the first edge that samples the high command, with no low-side handoff. Raising skip_ni while the low phase has completed turns ls_gate_o back on.
- R7: en_i = 0 or lockout_i = 1 forces both gates to 0 from the next edge on, whatever the command.
- R8: An idle command (pwm_cmd_i[1] = 1) forces both gates to 0 from the next edge. Leaving idle goes through the normal comparator handoff of R3 or R4, with a both-off gap of DEAD_CYC cycles.
- R9: In steady state with skip_ni = 1, hs_gate_o equals the command and ls_gate_o is its complement. With skip_ni = 0, ls_gate_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_cmd_i | input | 2 | Qualified command: 00 low, 01 high, 1x idle |
| en_i | input | 1 | Driver enable, active high |
| lockout_i | input | 1 | Supply under-voltage lockout, active high |
| skip_ni | input | 1 | 0 selects diode emulation (low-side held off) |
| lsg_low_i | input | 1 | Low-side gate below threshold |
| sw_low_i | input | 1 | Switch node below threshold |
| hsvgs_low_i | input | 1 | High-side gate-source voltage below threshold |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
The bench uses a comparator model that lags each gate by one cycle. It measures the exact number of both-off cycles for every kind of handoff. A design that skipped the comparator, or counted the deadband off by one, would show a gap other than DEAD_CYC. A design without the fallback timer would leave the low side off for good when the switch node is held high. A design that let the late switch-node path lose to the timer would show a gap of TMO_CYC instead of the shorter one. The bench also aborts a rising handoff halfway through, to catch a design that fires the high side from a stale count. It sweeps pulse widths with skip mode both on and off, to catch a low side that leaks through in diode emulation. It drops enable, lockout and the idle command while each gate is on, to catch a force-off that waits for the next command edge.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_HS,
    ST_HS_ON,
    ST_WAIT_LS,
    ST_LS_ON
  } seq_state_e;

  localparam logic [1:0] CMD_LO = 2'b00;
  localparam logic [1:0] CMD_HI = 2'b01;
endpackage

// File: rtl/gate_cmd_qualify.sv
module gate_cmd_qualify
  import gate_seq_pkg::*;
(
  input  logic [1:0] pwm_cmd_i,
  input  logic       en_i,
  input  logic       lockout_i,
  output logic       force_off_o,
  output logic       pwm_hi_o
);
  logic idle;
  assign idle        = pwm_cmd_i[1];
  assign force_off_o = idle || !en_i || lockout_i;
  assign pwm_hi_o    = (pwm_cmd_i == CMD_HI);
endmodule

// File: rtl/gate_hold_counter.sv
// Counts qualified edges; done_o when the N-th one is being sampled.
// STICKY keeps counting after the first qualifying edge.
module gate_hold_counter #(
  parameter int unsigned N      = 3,
  parameter bit          STICKY = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(N + 1);

  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         active;

  assign active = cond_i || (STICKY && run_q);
  assign done_o = active && (cnt_q == W'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (active) begin
      if (!done_o) cnt_q <= cnt_q + 1'b1;
      run_q <= 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
  import gate_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       force_off_i,
  input  logic       pwm_hi_i,
  input  logic       skip_ni,
  input  logic       hs_ready_i,
  input  logic       ls_ready_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;
  seq_state_e rise_tgt;

  // diode emulation: no low-side handoff to wait for
  assign rise_tgt = skip_ni ? ST_WAIT_HS : ST_HS_ON;

  always_comb begin
    state_d = state_q;
    if (force_off_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     state_d = pwm_hi_i ? rise_tgt : ST_WAIT_LS;
        ST_WAIT_HS: begin
          if (!pwm_hi_i)                    state_d = ST_WAIT_LS;
          else if (!skip_ni || hs_ready_i)  state_d = ST_HS_ON;
        end
        ST_HS_ON:   if (!pwm_hi_i) state_d = ST_WAIT_LS;
        ST_WAIT_LS: begin
          if (pwm_hi_i)        state_d = rise_tgt;
          else if (ls_ready_i) state_d = ST_LS_ON;
        end
        ST_LS_ON:   if (pwm_hi_i) state_d = rise_tgt;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/halfbridge_gate_seq.sv
module halfbridge_gate_seq
  import gate_seq_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3,
  parameter int unsigned TMO_CYC  = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_cmd_i,
  input  logic       en_i,
  input  logic       lockout_i,
  input  logic       skip_ni,
  input  logic       lsg_low_i,
  input  logic       sw_low_i,
  input  logic       hsvgs_low_i,
  output logic       hs_gate_o,
  output logic       ls_gate_o
);
  logic       force_off, pwm_hi;
  logic       hs_ready, sw_ready, tmo_ready;
  seq_state_e state;

  gate_cmd_qualify u_qual (
    .pwm_cmd_i   (pwm_cmd_i),
    .en_i        (en_i),
    .lockout_i   (lockout_i),
    .force_off_o (force_off),
    .pwm_hi_o    (pwm_hi)
  );

  // low-side gate confirmed off -> high-side may turn on
  gate_hold_counter #(.N(DEAD_CYC), .STICKY(1'b0)) u_dead_on (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != ST_WAIT_HS),
    .cond_i (lsg_low_i),
    .done_o (hs_ready)
  );

  // switch node confirmed low -> low-side may turn on
  gate_hold_counter #(.N(DEAD_CYC), .STICKY(1'b0)) u_dead_off (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != ST_WAIT_LS),
    .cond_i (sw_low_i),
    .done_o (sw_ready)
  );

  // fallback: started by high-side discharge, runs to expiry
  gate_hold_counter #(.N(TMO_CYC), .STICKY(1'b1)) u_timeout (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state != ST_WAIT_LS),
    .cond_i (hsvgs_low_i),
    .done_o (tmo_ready)
  );

  gate_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .force_off_i (force_off),
    .pwm_hi_i    (pwm_hi),
    .skip_ni     (skip_ni),
    .hs_ready_i  (hs_ready),
    .ls_ready_i  (sw_ready || tmo_ready),
    .state_o     (state)
  );

  assign hs_gate_o = (state == ST_HS_ON);
  assign ls_gate_o = (state == ST_LS_ON) && skip_ni;
endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] pwm_cmd_i,
  input logic       en_i,
  input logic       lockout_i,
  input logic       skip_ni,
  input logic       lsg_low_i,
  input logic       hs_gate_o,
  input logic       ls_gate_o
);
  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_gate_o && ls_gate_o));

  a_r7_disable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || lockout_i) |=> (!hs_gate_o && !ls_gate_o));

  a_r8_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_cmd_i[1] |=> (!hs_gate_o && !ls_gate_o));

  a_r6_skip_ls_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !skip_ni |-> !ls_gate_o);

  a_r3_hs_after_lsg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_gate_o) |-> ($past(lsg_low_i) || !$past(skip_ni)));

  a_r4_ls_after_hs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_gate_o) |-> !$past(hs_gate_o));
endmodule

bind halfbridge_gate_seq gate_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwm_cmd_i (pwm_cmd_i),
  .en_i      (en_i),
  .lockout_i (lockout_i),
  .skip_ni   (skip_ni),
  .lsg_low_i (lsg_low_i),
  .hs_gate_o (hs_gate_o),
  .ls_gate_o (ls_gate_o)
);

// File: tb/tb_halfbridge_gate_seq.sv
module tb_halfbridge_gate_seq;
  localparam int CLK_P = 10;
  localparam int DEAD  = 3;
  localparam int TMO   = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwm_cmd = 2'b10;
  logic       en = 1'b1, lockout = 1'b0, skip_n = 1'b1;
  logic       lsg_low = 1'b1, sw_low = 1'b1, hsvgs_low = 1'b1;
  logic       hs, ls;
  bit         sw_stuck = 1'b0;
  int         total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  halfbridge_gate_seq #(.DEAD_CYC(DEAD), .TMO_CYC(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_cmd_i(pwm_cmd), .en_i(en),
    .lockout_i(lockout), .skip_ni(skip_n), .lsg_low_i(lsg_low),
    .sw_low_i(sw_low), .hsvgs_low_i(hsvgs_low), .hs_gate_o(hs), .ls_gate_o(ls)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock; comparator model lags each gate by one cycle
  task automatic step();
    @(posedge clk);
    #1;
    lsg_low   = !ls;
    sw_low    = !hs && !sw_stuck;
    hsvgs_low = !hs;
    chk(!(hs && ls), "R2 overlap", {hs, ls}, 0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic rise_gap(output int gap, output bit got);
    gap = 0; got = 0;
    pwm_cmd = 2'b01;
    for (int i = 0; i < 40; i++) begin
      step();
      if (hs) begin got = 1; break; end
      if (!ls) gap++;
    end
  endtask

  // rel > 0: switch node released after that many edges; rel < 0: never
  task automatic fall_gap(input int rel, output int gap, output bit got);
    gap = 0; got = 0;
    sw_stuck = (rel != 0);
    pwm_cmd = 2'b00;
    for (int n = 1; n <= 40; n++) begin
      step();
      if (ls) begin got = 1; break; end
      if (!hs) gap++;
      if (n == rel) begin sw_stuck = 0; sw_low = !hs; end
    end
    sw_stuck = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int  g;
    bit  got;
    // R1 reset
    #(CLK_P*3 + 2);
    chk(!hs && !ls, "R1 in reset", {hs, ls}, 0);
    rst_n = 1'b1;
    steps(5);
    chk(!hs && !ls, "R1 idle after reset", {hs, ls}, 0);

    // R8 exit idle to low
    fall_gap(0, g, got);
    chk(got && g == DEAD, "R8 exit idle low gap", g, DEAD);

    // R3 rise, R9 steady
    rise_gap(g, got);
    chk(got && g == DEAD, "R3 rise gap", g, DEAD);
    steps(10);
    chk(hs && !ls, "R9 steady high", {hs, ls}, 2);

    // R4 fall
    fall_gap(0, g, got);
    chk(got && g == DEAD, "R4 fall gap", g, DEAD);
    steps(10);
    chk(!hs && ls, "R9 steady low", {hs, ls}, 1);

    // R5 timeout: switch node never trips
    rise_gap(g, got);
    steps(3);
    fall_gap(-1, g, got);
    chk(got && g == TMO, "R5 timeout gap", g, TMO);

    // R4 late switch node, shorter than timeout
    rise_gap(g, got);
    steps(3);
    fall_gap(2, g, got);
    chk(got && g == 2 + DEAD - 1, "R4 late sw gap", g, 2 + DEAD - 1);

    // R3 aborted rise: hs must never rise
    steps(5);
    pwm_cmd = 2'b01;
    step();
    got = 0;
    fall_gap(0, g, got);
    chk(got, "R3 abort ls back", got, 1);
    chk(!hs, "R3 abort hs stayed off", hs, 0);

    // R6 skip mode
    steps(5);
    skip_n = 1'b0;
    #1;
    chk(!ls, "R6 skip drops ls", ls, 0);
    rise_gap(g, got);
    chk(got && g == 0, "R6 skip hs immediate", g, 0);
    pwm_cmd = 2'b00;
    steps(12);
    chk(!hs && !ls, "R6 skip ls held off", {hs, ls}, 0);
    skip_n = 1'b1;
    step();
    chk(ls, "R6 skip release ls on", ls, 1);

    // R7 enable and lockout
    rise_gap(g, got);
    steps(2);
    en = 1'b0;
    step();
    chk(!hs && !ls, "R7 enable low hs off", {hs, ls}, 0);
    steps(5);
    chk(!hs && !ls, "R7 enable low held", {hs, ls}, 0);
    en = 1'b1;
    steps(DEAD + 2);
    chk(hs, "R7 re-enable follows pwm", hs, 1);
    fall_gap(0, g, got);
    steps(2);
    lockout = 1'b1;
    step();
    chk(!hs && !ls, "R7 lockout ls off", {hs, ls}, 0);
    lockout = 1'b0;
    steps(DEAD + 2);

    // R8 idle while high, exit idle high
    rise_gap(g, got);
    steps(2);
    pwm_cmd = 2'b11;
    step();
    chk(!hs && !ls, "R8 idle forces off", {hs, ls}, 0);
    steps(4);
    rise_gap(g, got);
    chk(got && g == DEAD, "R8 exit idle high gap", g, DEAD);

    // R9 sweep of half periods and skip setting
    for (int sk = 0; sk < 2; sk++) begin
      skip_n = sk[0];
      for (int hp = TMO + 2; hp < TMO + 7; hp++) begin
        for (int ph = 0; ph < 2; ph++) begin
          pwm_cmd = ph[0] ? 2'b00 : 2'b01;
          steps(hp);
          chk(hs == !ph[0] && ls == (ph[0] && sk[0]), "R9 sweep",
              {hs, ls}, {!ph[0], ph[0] && sk[0]});
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule